// File: doc/BRIEF.md
# Serial-In Shift Register with Strobed Storage and Gated Parallel Outputs

The block is an eight-stage serial-to-parallel converter. A serial bit enters the first stage on every rising edge of the shift clock, and each earlier bit moves one stage toward the last stage. Every shift stage has its own storage latch. While the strobe is high the latches are transparent, so the parallel outputs follow the shift stages. On the falling edge of the strobe the latches capture the current stage values, and they hold them while the strobe stays low. Software can therefore shift in a whole new word while the outputs keep showing the old one, and then update all eight outputs at once.

The parallel outputs have three-state behaviour. An active-high enable sets a per-bit drive-enable vector, and the pads or the bus fabric act on that vector. Two serial outputs support chaining. The first shows the last stage directly. The second captures the last stage on the falling clock edge that follows, so it is half a period late. A downstream device that shifts on the next rising edge therefore sees a stable bit with no clock-skew race.

A synchronous active-high reset clears the shift stages on a rising edge and the delayed serial output on a falling edge. The storage latches are forced to zero for as long as the reset is held.

Top module: `sipo_latched_out`

## Requirements
- R1: On each rising clock edge with reset low, stage 0 (par_q bit 0) takes ser_in and stage i takes the old value of stage i-1, for i from 1 to 7.
- R2: ser_q equals stage 7 and changes only just after rising clock edges.
- R3: casc_q takes the value of stage 7 on each falling clock edge. During the high phase after a rising edge it still holds the value stage 7 had before that edge.
- R4: While strobe is high, par_q equals the current shift stages, bit i showing stage i.
- R5: While strobe is low, par_q holds the stage values present when strobe fell, whatever is shifted in.
- R6: par_drv is all ones while oe is high and all zeros while oe is low. A zero bit means that output is high impedance. oe never changes par_q.
- R7: oe has no effect on ser_q or casc_q.
- R8: With rst high, a rising edge clears all stages, a falling edge clears casc_q, and par_q reads zero while rst stays high.
- R9: If casc_q of one instance feeds ser_in of a second instance, the pair acts as one sixteen-stage register with no lost or repeated bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages shift on the rising edge, cascade tap on the falling edge |
| rst | input | 1 | Synchronous active-high clear |
| ser_in | input | 1 | Serial data entering stage 0 |
| strobe | input | 1 | Storage latch control; high = transparent, low = hold |
| oe | input | 1 | Active-high parallel output enable |
| par_q | output | 8 | Storage latch contents presented to the parallel outputs |
| par_drv | output | 8 | Per-bit drive enable for par_q; 0 = high impedance |
| ser_q | output | 1 | Last shift stage, direct |
| casc_q | output | 1 | Last shift stage, retimed on the falling clock edge |

## Verification
Shift-stage results and ser_q are due just after the rising edge that shifts them in. The bench samples them 1 ns after that edge and again in the low phase. casc_q is due at the following falling edge, so it is checked twice: 1 ns after the rising edge, where it must still show the old last stage, and 1 ns after the falling edge, where it must show the new one. Latch and drive-enable results follow strobe and oe within the same cycle with no clock involved. The bench sets its expected values the moment it drives those inputs and compares them only in the low phase, after every register has settled.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    localparam int unsigned STAGES_DEFAULT = 8;

    // Control bundle carried from the top into the storage and drive stages
    typedef struct packed {
        logic clear;
        logic transparent;
        logic drive;
    } sipo_ctrl_t;

    // Next state of a shift chain of width w (only low w bits meaningful)
    function automatic logic [63:0] shift_in_bit(input logic [63:0] cur,
                                                 input logic       din);
        return {cur[62:0], din};
    endfunction

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         din,
    output logic [W-1:0] stage
);
    localparam int unsigned LAST = W - 1;

    // Each stage is its own flop so that a single stage can be retimed later
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic feed;
        if (i == 0) begin : g_head
            assign feed = din;
        end else begin : g_body
            assign feed = stage[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[i] <= 1'b0;
            end else begin
                stage[i] <= feed;
            end
        end
    end

    logic unused_last;
    assign unused_last = stage[LAST];

endmodule

// File: rtl/sipo_store_latch.sv
module sipo_store_latch #(
    parameter int unsigned W = 8
) (
    input  sipo_pkg::sipo_ctrl_t ctrl,
    input  logic [W-1:0]         d,
    output logic [W-1:0]         q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_latch begin
            if (ctrl.clear) begin
                q[i] <= 1'b0;
            end else if (ctrl.transparent) begin
                q[i] <= d[i];
            end
        end
    end

endmodule

// File: rtl/sipo_cascade_tap.sv
module sipo_cascade_tap (
    input  logic clk,
    input  logic rst,
    input  logic last_stage,
    output logic tap
);
    // Retimed on the falling edge: a downstream rising edge sees a settled bit
    always_ff @(negedge clk) begin
        if (rst) begin
            tap <= 1'b0;
        end else begin
            tap <= last_stage;
        end
    end

endmodule

// File: rtl/sipo_out_drive.sv
module sipo_out_drive #(
    parameter int unsigned W = 8
) (
    input  sipo_pkg::sipo_ctrl_t ctrl,
    input  logic [W-1:0]         held,
    output logic [W-1:0]         pad_val,
    output logic [W-1:0]         pad_en
);
    for (genvar i = 0; i < W; i++) begin : g_pad
        assign pad_val[i] = held[i];
        assign pad_en[i]  = ctrl.drive;
    end

endmodule

// File: rtl/sipo_latched_out.sv
module sipo_latched_out #(
    parameter int unsigned W = sipo_pkg::STAGES_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    input  logic         strobe,
    input  logic         oe,
    output logic [W-1:0] par_q,
    output logic [W-1:0] par_drv,
    output logic         ser_q,
    output logic         casc_q
);
    import sipo_pkg::*;

    localparam int unsigned LAST = W - 1;

    logic [W-1:0] shift_q;
    logic [W-1:0] held_q;
    sipo_ctrl_t   ctrl;

    assign ctrl.clear       = rst;
    assign ctrl.transparent = strobe;
    assign ctrl.drive       = oe;

    sipo_shift_chain #(.W(W)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .din   (ser_in),
        .stage (shift_q)
    );

    sipo_store_latch #(.W(W)) u_store (
        .ctrl (ctrl),
        .d    (shift_q),
        .q    (held_q)
    );

    sipo_cascade_tap u_tap (
        .clk        (clk),
        .rst        (rst),
        .last_stage (shift_q[LAST]),
        .tap        (casc_q)
    );

    sipo_out_drive #(.W(W)) u_drive (
        .ctrl    (ctrl),
        .held    (held_q),
        .pad_val (par_q),
        .pad_en  (par_drv)
    );

    assign ser_q = shift_q[LAST];

endmodule

// File: rtl/sipo_latched_out_chk.sv
module sipo_latched_out_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ser_in,
    input logic         strobe,
    input logic         oe,
    input logic [W-1:0] shift_q,
    input logic [W-1:0] par_q,
    input logic [W-1:0] par_drv,
    input logic         ser_q,
    input logic         casc_q
);
    logic seen_rst  = 1'b0;
    logic prev_rst  = 1'b1;

    always_ff @(posedge clk) begin
        seen_rst <= seen_rst | rst;
        prev_rst <= rst;
    end

    logic live;
    assign live = seen_rst && !prev_rst;

    assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
        live |-> shift_q == {$past(shift_q[W-2:0]), $past(ser_in)});

    assert_serial_out_R2: assert property (@(posedge clk) disable iff (rst)
        live |-> ser_q == $past(shift_q[W-2]));

    assert_cascade_lag_R3: assert property (@(posedge clk) disable iff (rst)
        live |-> casc_q == ser_q);

    assert_transparent_R4: assert property (@(posedge clk) disable iff (rst)
        (seen_rst && strobe) |-> par_q == shift_q);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (live && !strobe && !$past(strobe)) |-> $stable(par_q));

    assert_drive_off_R6: assert property (@(posedge clk) disable iff (rst)
        !oe |-> par_drv == '0);

    assert_drive_on_R6: assert property (@(posedge clk) disable iff (rst)
        oe |-> par_drv == {W{1'b1}});

    assert_reset_clear_R8: assert property (@(posedge clk)
        (seen_rst && prev_rst) |-> shift_q == '0);

endmodule

bind sipo_latched_out sipo_latched_out_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .strobe  (strobe),
    .oe      (oe),
    .shift_q (shift_q),
    .par_q   (par_q),
    .par_drv (par_drv),
    .ser_q   (ser_q),
    .casc_q  (casc_q)
);

// File: tb/sipo_latched_out_bench.sv
module sipo_latched_out_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic strobe = 1'b0;
    logic oe = 1'b0;

    logic [7:0] a_par, a_drv, b_par, b_drv;
    logic       a_ser, a_casc, b_ser, b_casc;

    always #5 clk = ~clk;

    sipo_latched_out u_sipo_latched_out (
        .clk(clk), .rst(rst), .ser_in(ser_in), .strobe(strobe), .oe(oe),
        .par_q(a_par), .par_drv(a_drv), .ser_q(a_ser), .casc_q(a_casc)
    );

    sipo_latched_out u_tail (
        .clk(clk), .rst(rst), .ser_in(a_casc), .strobe(strobe), .oe(oe),
        .par_q(b_par), .par_drv(b_drv), .ser_q(b_ser), .casc_q(b_casc)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state, from the requirements only
    logic [7:0] ma = '0, mb = '0, la = '0, lb = '0;
    logic       mca = 1'b0, mcb = 1'b0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] shift8(input logic [7:0] cur, input logic din);
        return {cur[6:0], din};
    endfunction

    // Called 1 ns after a falling edge; runs one full clock cycle
    task automatic tick(input logic sin, input logic stb, input logic en, input logic rs);
        logic old_a7;
        ser_in = sin; strobe = stb; oe = en; rst = rs;
        if (rs) begin la = '0; lb = '0; end
        else if (stb) begin la = ma; lb = mb; end
        old_a7 = ma[7];
        @(posedge clk); #1;
        if (rs) begin ma = '0; mb = '0; end
        else begin mb = shift8(mb, mca); ma = shift8(ma, sin); end
        if (rs) begin la = '0; lb = '0; end
        else if (stb) begin la = ma; lb = mb; end
        if (!rs) begin
            chk("R3 casc before falling edge", {7'd0, a_casc}, {7'd0, old_a7});
            chk("R2 ser after rising edge", {7'd0, a_ser}, {7'd0, ma[7]});
        end
        @(negedge clk); #1;
        if (rs) begin mca = 1'b0; mcb = 1'b0; end
        else begin mca = ma[7]; mcb = mb[7]; end
        if (rs) begin
            chk("R8 par cleared", a_par, 8'h00);
            chk("R8 casc cleared", {7'd0, a_casc}, 8'h00);
        end else begin
            chk(stb ? "R4 par follows stages" : "R5 par held", a_par, la);
            chk(stb ? "R4 tail par follows" : "R5 tail par held", b_par, lb);
            chk("R3 casc after falling edge", {7'd0, a_casc}, {7'd0, mca});
            chk("R9 tail serial", {7'd0, b_ser}, {7'd0, mb[7]});
            chk("R9 tail casc", {7'd0, b_casc}, {7'd0, mcb});
        end
        chk("R6 drive enables", a_drv, en ? 8'hFF : 8'h00);
        chk("R6 tail drive enables", b_drv, en ? 8'hFF : 8'h00);
        if (!en) chk("R7 ser unaffected by oe", {7'd0, a_ser}, {7'd0, ma[7]});
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5A17_C0DE);
        @(negedge clk); #1;
        // R8 reset state
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R8 shift cleared", a_par, 8'h00);

        // R1 load A5 msb first, strobe high
        for (int i = 7; i >= 0; i--) tick(8'hA5 >> i, 1'b1, 1'b1, 1'b0);
        chk("R1 word loaded", a_par, 8'hA5);

        // R5 shift 3C with strobe low: outputs must keep A5
        for (int i = 7; i >= 0; i--) tick(8'h3C >> i, 1'b0, 1'b1, 1'b0);
        chk("R5 held during shift", a_par, 8'hA5);
        chk("R9 tail received word", mb, 8'hA5);

        // R6 oe low: drive off, value kept
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 value kept with oe low", a_par, 8'hA5);

        // R4 strobe high exposes current stages
        tick(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R4 stages exposed", a_par, ma);

        // Constrained random phase
        for (int i = 0; i < 400; i++) begin
            logic r_sin, r_stb, r_en, r_rs;
            r_sin = 1'($urandom);
            r_stb = ($urandom % 4) == 0;
            r_en  = ($urandom % 3) != 0;
            r_rs  = ($urandom % 64) == 0;
            tick(r_sin, r_stb, r_en, r_rs);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule